// File: doc/BRIEF.md
# Mixed-Sign Byte Dot-Product Accumulator

This block is a group of SIMD execution lanes. Each 32-bit lane multiplies four unsigned bytes from the first source vector with four signed bytes from the second source vector, adds the four products, and adds that sum to the lane's accumulator value. One request selects either a 64-bit vector (two lanes) or a 128-bit vector (four lanes). The updated accumulator vector is returned one cycle after the request is accepted.

Requests enter through a valid/ready handshake. A single output register holds the response until the consumer takes it. For a 128-bit request, the block also checks the three register index fields it receives. If any of them is not even, the response is flagged as undefined and no result-valid is raised, so the accumulator is never written back.

Register-file access, the feature-enable check and exception delivery stay outside the block.

Top module: `mixdot_acc_top`

## Requirements
- R1: Each active lane returns its accumulator value plus the sum of its four byte products, computed without loss of precision.
- R2: Bytes of `src_a_i` are read as unsigned (0..255) and bytes of `src_b_i` as two's-complement signed (-128..127), so 255 times 0x80 gives -32640 and 255 times 0x7F gives 32385.
- R3: Lane e covers bits [32e+31:32e]. Its byte b pairs bits [32e+8b+7:32e+8b] of both sources.
- R4: With `wide_i`=0, lanes 0 and 1 are computed and `result_o[127:64]` equals `acc_i[127:64]` unchanged.
- R5: With `wide_i`=1, all four lanes are computed, and the upper 64-bit half is handled the same way as the lower half.
- R6: With `wide_i`=1, if bit 0 of `dst_idx_i`, `a_idx_i` or `b_idx_i` is 1, the response raises `undef_o` and keeps `out_valid_o` low. With `wide_i`=0, the index values have no effect.
- R7: Lane accumulation wraps modulo 2^32, with no saturation.
- R8: A request accepted at a clock edge (`in_valid_i` and `in_ready_o` both high) appears on the outputs right after that edge. `in_ready_o` is high when no response is pending or when `out_ready_i` is high. A response that is not taken keeps its outputs stable.
- R9: During and right after reset, `out_valid_o` and `undef_o` are 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request can be accepted |
| wide_i | input | 1 | 0: 64-bit vector, 1: 128-bit vector |
| dst_idx_i | input | 5 | Accumulator/destination register index |
| a_idx_i | input | 5 | First source register index |
| b_idx_i | input | 5 | Second source register index |
| src_a_i | input | 128 | Unsigned byte operand vector |
| src_b_i | input | 128 | Signed byte operand vector |
| acc_i | input | 128 | Accumulator input vector |
| out_valid_o | output | 1 | Defined result available |
| undef_o | output | 1 | Response is an undefined operation |
| out_ready_i | input | 1 | Consumer takes the response |
| result_o | output | 128 | Updated accumulator vector |

## Verification
Internal state is limited to the output register, so errors show up on the ports on the first edge after acceptance. Three kinds of error can occur:
- A wrong sign or zero extension, a byte-pairing slip or a narrow sum shows up as a lane value that differs from the model. This is most visible at the byte extremes and at wrap-around.
- A lost hold shows up as a result or valid flag that changes while the consumer stalls.
- An alignment check that is wrong shows up as a result-valid on a misaligned wide request, or as a missing valid on a narrow one.

// File: rtl/mixdot_pkg.sv
package mixdot_pkg;
  parameter int unsigned BYTE_W    = 8;
  parameter int unsigned LANE_B    = 4;
  parameter int unsigned LANE_W    = BYTE_W * LANE_B;
  parameter int unsigned CHUNK_W   = 64;
  parameter int unsigned CHUNKS    = 2;
  parameter int unsigned VEC_W     = CHUNK_W * CHUNKS;
  parameter int unsigned LANES     = VEC_W / LANE_W;
  parameter int unsigned CHUNK_LN  = CHUNK_W / LANE_W;
  parameter int unsigned IDX_W     = 5;
  parameter int unsigned PROD_W    = 2 * BYTE_W + 1;
  parameter int unsigned SUM_W     = PROD_W + $clog2(LANE_B);

  typedef logic [VEC_W-1:0] vec_t;

  typedef struct packed {
    logic undef;
    vec_t res;
  } resp_t;
endpackage

// File: rtl/mixdot_lane.sv
module mixdot_lane
  import mixdot_pkg::*;
(
  input  logic              en_i,
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic [LANE_W-1:0] acc_i,
  output logic [LANE_W-1:0] res_o
);
  logic signed [PROD_W-1:0] prod [LANE_B];
  logic signed [SUM_W-1:0]  sum;

  always_comb begin
    sum = '0;
    for (int k = 0; k < LANE_B; k++) begin
      // zero-extend a, sign-extend b
      prod[k] = $signed({1'b0, a_i[k*BYTE_W +: BYTE_W]}) * $signed(b_i[k*BYTE_W +: BYTE_W]);
      sum     = sum + {{(SUM_W-PROD_W){prod[k][PROD_W-1]}}, prod[k]};
    end
  end

  assign res_o = en_i ? acc_i + {{(LANE_W-SUM_W){sum[SUM_W-1]}}, sum} : acc_i;
endmodule

// File: rtl/mixdot_align.sv
module mixdot_align
  import mixdot_pkg::*;
(
  input  logic             wide_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  input  logic [IDX_W-1:0] a_idx_i,
  input  logic [IDX_W-1:0] b_idx_i,
  output logic             undef_o
);
  // index bits that must be zero when a request spans all chunks
  localparam logic [IDX_W-1:0] ALIGN_MASK = IDX_W'(CHUNKS - 1);

  assign undef_o = wide_i & (|((dst_idx_i | a_idx_i | b_idx_i) & ALIGN_MASK));
endmodule

// File: rtl/mixdot_acc_top.sv
module mixdot_acc_top
  import mixdot_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             wide_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  input  logic [IDX_W-1:0] a_idx_i,
  input  logic [IDX_W-1:0] b_idx_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  input  logic [VEC_W-1:0] acc_i,
  output logic             out_valid_o,
  output logic             undef_o,
  input  logic             out_ready_i,
  output logic [VEC_W-1:0] result_o
);
  vec_t  lane_res;
  logic  undef_d;
  resp_t resp_q;
  logic  full_q;
  logic  accept;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    logic lane_en;
    if (e < CHUNK_LN) begin : g_low
      assign lane_en = 1'b1;
    end else begin : g_high
      assign lane_en = wide_i;
    end
    mixdot_lane u_lane (
      .en_i  (lane_en),
      .a_i   (src_a_i[e*LANE_W +: LANE_W]),
      .b_i   (src_b_i[e*LANE_W +: LANE_W]),
      .acc_i (acc_i[e*LANE_W +: LANE_W]),
      .res_o (lane_res[e*LANE_W +: LANE_W])
    );
  end

  mixdot_align u_align (
    .wide_i    (wide_i),
    .dst_idx_i (dst_idx_i),
    .a_idx_i   (a_idx_i),
    .b_idx_i   (b_idx_i),
    .undef_o   (undef_d)
  );

  assign in_ready_o = ~full_q | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      resp_q <= '0;
    end else begin
      if (accept) begin
        full_q       <= 1'b1;
        resp_q.undef <= undef_d;
        resp_q.res   <= lane_res;
      end else if (out_ready_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = full_q & ~resp_q.undef;
  assign undef_o     = full_q & resp_q.undef;
  assign result_o    = resp_q.res;
endmodule

// File: rtl/mixdot_chk.sv
module mixdot_chk
  import mixdot_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             wide_i,
  input logic [IDX_W-1:0] dst_idx_i,
  input logic [IDX_W-1:0] a_idx_i,
  input logic [IDX_W-1:0] b_idx_i,
  input logic [VEC_W-1:0] acc_i,
  input logic             out_valid_o,
  input logic             undef_o,
  input logic             out_ready_i,
  input logic [VEC_W-1:0] result_o
);
  logic acc_ok;
  logic bad_idx;
  assign acc_ok  = in_valid_i & in_ready_o;
  assign bad_idx = dst_idx_i[0] | a_idx_i[0] | b_idx_i[0];

  // R4
  narrow_upper_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && !wide_i |=> out_valid_o && result_o[VEC_W-1:VEC_W/2] == $past(acc_i[VEC_W-1:VEC_W/2]));

  // R6
  misaligned_undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && wide_i && bad_idx |=> undef_o && !out_valid_o);

  // R6
  aligned_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_ok && (!wide_i || !bad_idx) |=> out_valid_o && !undef_o);

  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o || undef_o) && !out_ready_i |=> $stable(result_o) && $stable(out_valid_o) && $stable(undef_o));

  // R8
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o && !undef_o |-> in_ready_o);
endmodule

bind mixdot_acc_top mixdot_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .wide_i      (wide_i),
  .dst_idx_i   (dst_idx_i),
  .a_idx_i     (a_idx_i),
  .b_idx_i     (b_idx_i),
  .acc_i       (acc_i),
  .out_valid_o (out_valid_o),
  .undef_o     (undef_o),
  .out_ready_i (out_ready_i),
  .result_o    (result_o)
);

// File: tb/sim_mixdot_acc_top.sv
module sim_mixdot_acc_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         wide = 1'b0;
  logic [4:0]   dst_idx = '0, a_idx = '0, b_idx = '0;
  logic [127:0] src_a = '0, src_b = '0, acc = '0;
  logic         out_valid, undef;
  logic         out_ready = 1'b1;
  logic [127:0] result;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mixdot_acc_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .wide_i(wide), .dst_idx_i(dst_idx), .a_idx_i(a_idx), .b_idx_i(b_idx),
    .src_a_i(src_a), .src_b_i(src_b), .acc_i(acc),
    .out_valid_o(out_valid), .undef_o(undef), .out_ready_i(out_ready), .result_o(result)
  );

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [127:0] c, input logic w);
    logic [127:0] r = c;
    for (int e = 0; e < 4; e++) begin
      if (e < 2 || w) begin
        int s = 0;
        for (int k = 0; k < 4; k++)
          s += int'(a[e*32+k*8 +: 8]) * int'($signed(b[e*32+k*8 +: 8]));
        r[e*32 +: 32] = c[e*32 +: 32] + 32'(s);
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    @(negedge clk);
    wide = w; src_a = a; src_b = b; acc = c; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(input string req, input logic w, input logic [127:0] a,
                        input logic [127:0] b, input logic [127:0] c);
    issue(w, a, b, c);
    check({req, " valid"}, {126'd0, out_valid, undef}, 128'd2);
    check(req, result, model(a, b, c, w));
  endtask

  task automatic t_reset;
    #1;
    check("R9 during reset", {125'd0, in_ready, out_valid, undef}, 128'd4);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", {125'd0, in_ready, out_valid, undef}, 128'd4);
  endtask

  task automatic t_extremes;
    run_op("R2 255x-128", 1'b1, {16{8'hFF}}, {16{8'h80}}, '0);
    check("R2 lane value", {96'd0, result[31:0]}, {96'd0, 32'hFFFE0200});
    run_op("R2 255x127", 1'b1, {16{8'hFF}}, {16{8'h7F}}, '0);
    check("R2 lane value pos", {96'd0, result[31:0]}, 128'd129540);
    run_op("R2 0x-128", 1'b1, '0, {16{8'h80}}, {4{32'h1234_5678}});
    run_op("R1 mixed", 1'b1, 128'h0102_0304_FF00_80FE_1122_3344_5566_7788,
           128'hFF7F_8001_1020_30C0_F0E0_D0C0_0102_0304, 128'hDEAD_BEEF_0000_0001_7FFF_FFFF_8000_0000);
  endtask

  task automatic t_mapping;
    // R3: single nonzero byte per lane at distinct positions
    run_op("R3 byte map", 1'b1, 128'h0300_0000_0002_0000_0000_0100_0000_0004,
           128'hFD00_0000_0005_0000_0000_0700_0000_0009, '0);
    check("R3 lane vals", result, {32'hFFFF_FFF7, 32'd10, 32'd7, 32'd36});
  endtask

  task automatic t_wrap;
    run_op("R7 wrap up", 1'b1, {16{8'hFF}}, {16{8'h7F}}, {4{32'hFFFF_FFF0}});
    check("R7 wrap value", {96'd0, result[31:0]}, {96'd0, 32'd129524});
    run_op("R7 wrap down", 1'b0, {16{8'hFF}}, {16{8'h80}}, {4{32'h0000_0005}});
  endtask

  task automatic t_narrow;
    logic [127:0] c = 128'hA5A5_5A5A_0F0F_F0F0_1111_2222_3333_4444;
    dst_idx = 5'd1; a_idx = 5'd3; b_idx = 5'd7;
    run_op("R4 narrow odd idx", 1'b0, {16{8'h11}}, {16{8'hEE}}, c);
    check("R4 upper pass", {64'd0, result[127:64]}, {64'd0, c[127:64]});
    dst_idx = '0; a_idx = '0; b_idx = '0;
  endtask

  task automatic t_wide;
    run_op("R5 wide", 1'b1, {8{16'hC837}}, {8{16'h9A7B}}, {2{64'h0102_0304_0506_0708}});
    check("R5 halves equal", {64'd0, result[127:64]}, {64'd0, result[63:0]});
  endtask

  task automatic t_misalign;
    for (int m = 1; m < 8; m++) begin
      dst_idx = {4'd5, m[0]}; a_idx = {4'd2, m[1]}; b_idx = {4'd9, m[2]};
      issue(1'b1, {16{8'h01}}, {16{8'h01}}, '0);
      check($sformatf("R6 misalign case %0d", m), {126'd0, out_valid, undef}, 128'd1);
    end
    dst_idx = 5'd10; a_idx = 5'd4; b_idx = 5'd30;
    run_op("R6 aligned wide", 1'b1, {16{8'h02}}, {16{8'hFE}}, '0);
    dst_idx = '0; a_idx = '0; b_idx = '0;
  endtask

  task automatic t_stall;
    logic [127:0] a1 = {16{8'h10}}, b1 = {16{8'h03}};
    logic [127:0] a2 = {16{8'h20}}, b2 = {16{8'hFD}};
    @(negedge clk);
    wide = 1'b1; src_a = a1; src_b = b1; acc = '0; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    src_a = a2; src_b = b2;
    check("R8 stalled ready", {126'd0, in_ready, out_valid}, 128'd1);
    @(posedge clk);
    @(negedge clk);
    check("R8 hold result", result, model(a1, b1, '0, 1'b1));
    check("R8 hold valid", {127'd0, out_valid}, 128'd1);
    out_ready = 1'b1;
    #1;
    check("R8 ready on drain", {127'd0, in_ready}, 128'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 next result", result, model(a2, b2, '0, 1'b1));
    @(posedge clk);
    @(negedge clk);
    check("R8 drained", {126'd0, out_valid, undef}, 128'd0);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_extremes();
    t_mapping();
    t_wrap();
    t_narrow();
    t_wide();
    t_misalign();
    t_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule